// File: doc/BRIEF.md
# Eight-bit dual-compare timer

An 8-bit up-counter with two compare registers, a selectable count clock, selectable clearing, three status flags, three interrupt request lines and one waveform output. The count clock is either one tap of a free-running internal prescaler or a rising edge on an external clock input, which is first passed through a two-flop synchronizer. The counter can be cleared by a hit on either compare register or by a synchronized rising edge on an external clear input.

A CPU reaches five byte-wide registers over a simple single-cycle bus: the counter, compare A, compare B, a control byte and a status byte. Reads are combinational from the address. Writes take effect at the clock edge. The status byte holds the match and overflow flags, and also the two actions that a compare hit applies to the output pin. A reinitialization input returns the block to its reset state.

Top module: `dual_cmp_timer8`

## Requirements
- R1: After reset, the counter reads 0x00 at address 0, compare A reads 0xFF at address 1, compare B reads 0xFF at address 2, control reads 0x00 at address 3 and status reads 0x00 at address 4. Addresses 5 to 7 read 0x00. `wave_out` and all three interrupt outputs are 0.
- R2: Control bits [2:0] select the count clock. Code 0 holds the counter. Code k from 1 to 6 advances it once every 2^(2k-1) clock cycles. Code 7 advances it once per rising edge of `ext_clk_in`, seen after two synchronizer stages.
- R3: A bus write to the counter loads the written value, even when an increment or a clear falls in the same cycle.
- R4: Control bits [4:3] select the clear source: 00 none, 01 a hit on A, 10 a hit on B, 11 a synchronized rising edge of `ext_clr_in`. The counter becomes 0x00 at the edge that ends the triggering cycle, and a clear wins over an increment. Under code 00, hits and `ext_clr_in` leave the counter alone.
- R5: An increment from 0xFF gives 0x00 and sets the overflow flag, status bit 2.
- R6: A hit on A happens in a cycle where the counter equals compare A, when it did not equal it in the previous compared cycle. A hit sets status bit 0. B works the same way and sets status bit 1. In a cycle with a bus write to a compare register, that register produces no hit and its equality history is frozen.
- R7: `irq_cma` is status bit 0 AND control bit 5. `irq_cmb` is status bit 1 AND control bit 6. `irq_ovf` is status bit 2 AND control bit 7.
- R8: Writing 0 to a flag bit in status clears that flag, and writing 1 leaves it unchanged. A hardware set in the same cycle as a clearing write leaves the flag at 1.
- R9: Status bits [5:4] give the pin action for a hit on A, and bits [7:6] give the action for a hit on B. The codes are 00 keep, 01 drive 0, 10 drive 1, 11 toggle. The action applies at the edge after the hit. When both registers hit in the same cycle, B's code alone applies, even when that code is 00.
- R10: `reinit` high at a clock edge restores every value listed in R1, and also clears the prescaler and the synchronizers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reinit | input | 1 | Synchronous return to reset values, active high |
| ext_clk_in | input | 1 | Asynchronous external count clock |
| ext_clr_in | input | 1 | Asynchronous external clear request |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| irq_cma | output | 1 | Interrupt request, compare A |
| irq_cmb | output | 1 | Interrupt request, compare B |
| irq_ovf | output | 1 | Interrupt request, overflow |
| wave_out | output | 1 | Compare-driven waveform output |

## Verification
Two same-cycle collisions get targeted stimulus. The first is a CPU write to the counter on a cycle when the prescaler also fires: the bench issues back-to-back counter writes under divide-by-2, so that one of them must meet a tick, and expects the written value exactly. The second is a hardware flag set landing on the cycle of a clearing status write: the bench loads the counter to the compare value and writes status 0x00 on the very next cycle, which is the hit cycle, and expects the flag to read 1. A related case writes compare A on the hit cycle and expects no flag. Randomized count windows then confirm exact tick counts and overflow under several divide ratios.

// File: rtl/timer8_pkg.sv
// Package: shared widths, register addresses, field encodings and the
// control byte layout for the eight-bit dual-compare timer.
package timer8_pkg;

    localparam int unsigned CNT_W  = 8;
    localparam int unsigned BUS_W  = 8;
    localparam int unsigned ADDR_W = 3;

    // Register addresses on the CPU bus
    localparam logic [ADDR_W-1:0] REG_COUNT = 3'd0;
    localparam logic [ADDR_W-1:0] REG_CMPA  = 3'd1;
    localparam logic [ADDR_W-1:0] REG_CMPB  = 3'd2;
    localparam logic [ADDR_W-1:0] REG_CTRL  = 3'd3;
    localparam logic [ADDR_W-1:0] REG_STAT  = 3'd4;

    // Clock-select codes with a fixed meaning
    localparam logic [2:0] CS_HOLD = 3'd0;
    localparam logic [2:0] CS_EXT  = 3'd7;

    typedef enum logic [1:0] {
        CLR_NONE   = 2'b00,
        CLR_ON_A   = 2'b01,
        CLR_ON_B   = 2'b10,
        CLR_ON_EXT = 2'b11
    } clr_sel_e;

    typedef enum logic [1:0] {
        PIN_KEEP   = 2'b00,
        PIN_LOW    = 2'b01,
        PIN_HIGH   = 2'b10,
        PIN_TOGGLE = 2'b11
    } pin_act_e;

    // Control byte, MSB first
    typedef struct packed {
        logic       ie_ovf;
        logic       ie_b;
        logic       ie_a;
        clr_sel_e   clr;
        logic [2:0] clk_sel;
    } ctrl_t;

endpackage

// File: rtl/timer8_prescaler.sv
// Free-running prescaler. Tap i pulses for one cycle out of every 2^(2i+1).
// Assumes PSC_W >= 2*N_TAPS-1 so that every tap has its bits.
module timer8_prescaler #(
    parameter int unsigned PSC_W  = 11,
    parameter int unsigned N_TAPS = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reinit,
    output logic [N_TAPS-1:0] tap
);

    logic [PSC_W-1:0] psc_q;

    // Advance the shared divider chain every cycle
    always_ff @(posedge clk) begin
        if (!rst_n || reinit) psc_q <= '0;
        else                  psc_q <= psc_q + 1'b1;
    end

    // Each tap fires when its low-order bits are all ones
    for (genvar i = 0; i < N_TAPS; i++) begin : g_tap
        localparam int unsigned TOP = 2 * i;
        assign tap[i] = &psc_q[TOP:0];
    end

    p_tap_alternates_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tap[0] |=> !tap[0]);

endmodule

// File: rtl/timer8_edge_sync.sv
// Brings an asynchronous input into the clock domain through STAGES flops
// and gives a one-cycle pulse on each synchronized rising edge.
// Assumes the input stays high and low for at least two clock cycles each.
module timer8_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic reinit,
    input  logic async_in,
    output logic rise
);

    logic [STAGES-1:0] sync_q;
    logic              last_q;

    // Shift the input through the synchronizer and keep the last settled level
    always_ff @(posedge clk) begin
        if (!rst_n || reinit) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], async_in};
            last_q <= sync_q[STAGES-1];
        end
    end

    assign rise = sync_q[STAGES-1] & ~last_q;

    p_one_pulse_per_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

endmodule

// File: rtl/timer8_compare.sv
// One compare channel. It reports a hit when the counter starts to equal
// the compare value. The cycle of a bus write to the compare register
// is excluded, and it freezes the equality history.
module timer8_compare #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         reinit,
    input  logic [W-1:0] count,
    input  logic [W-1:0] cmp,
    input  logic         cmp_wr,
    output logic         hit
);

    logic eq_now;
    logic eq_q;

    // Equality is masked in the cycle the compare value is being written
    assign eq_now = (count == cmp) && !cmp_wr;

    // Remember equality from the last cycle that was compared
    always_ff @(posedge clk) begin
        if (!rst_n || reinit) eq_q <= 1'b0;
        else if (!cmp_wr)     eq_q <= eq_now;
    end

    assign hit = eq_now & ~eq_q;

    p_hit_is_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> !hit);

endmodule

// File: rtl/timer8_wave.sv
// Waveform output. It applies the pin action for a compare hit, and
// channel B has priority when both channels hit in the same cycle.
module timer8_wave
    import timer8_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     reinit,
    input  logic     hit_a,
    input  logic     hit_b,
    input  pin_act_e act_a,
    input  pin_act_e act_b,
    output logic     wave
);

    // Next pin level for one action code
    function automatic logic apply_act(input logic cur, input pin_act_e act);
        case (act)
            PIN_LOW:    return 1'b0;
            PIN_HIGH:   return 1'b1;
            PIN_TOGGLE: return ~cur;
            default:    return cur;
        endcase
    endfunction

    // Update the pin on a hit, with channel B taking priority
    always_ff @(posedge clk) begin
        if (!rst_n || reinit) wave <= 1'b0;
        else if (hit_b)       wave <= apply_act(wave, act_b);
        else if (hit_a)       wave <= apply_act(wave, act_a);
    end

    p_b_low_wins_r9: assert property (@(posedge clk) disable iff (!rst_n || reinit)
        (hit_b && act_b == PIN_LOW) |=> !wave);
    p_b_high_wins_r9: assert property (@(posedge clk) disable iff (!rst_n || reinit)
        (hit_b && act_b == PIN_HIGH) |=> wave);

endmodule

// File: rtl/dual_cmp_timer8.sv
// Eight-bit dual-compare timer top. It holds the counter, the compare,
// control and status registers, and the bus decode. It selects the count
// clock and the clear source, and drives the interrupt requests.
// Assumes single-cycle bus writes and combinational reads.
module dual_cmp_timer8
    import timer8_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned PSC_W       = 11,
    parameter int unsigned N_TAPS      = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reinit,
    input  logic              ext_clk_in,
    input  logic              ext_clr_in,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              irq_cma,
    output logic              irq_cmb,
    output logic              irq_ovf,
    output logic              wave_out
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  cmpa_q;
    logic [CNT_W-1:0]  cmpb_q;
    ctrl_t             ctrl_q;
    pin_act_e          act_a_q;
    pin_act_e          act_b_q;
    logic              flag_a;
    logic              flag_b;
    logic              flag_ovf;

    logic [N_TAPS-1:0] tap;
    logic              ext_clk_rise;
    logic              ext_clr_rise;
    logic              hit_a;
    logic              hit_b;
    logic              tick;
    logic              do_clear;
    logic              ovf_set;

    logic cnt_wr;
    logic cmpa_wr;
    logic cmpb_wr;
    logic ctrl_wr;
    logic stat_wr;

    // Bus write decode
    assign cnt_wr  = bus_we && (bus_addr == REG_COUNT);
    assign cmpa_wr = bus_we && (bus_addr == REG_CMPA);
    assign cmpb_wr = bus_we && (bus_addr == REG_CMPB);
    assign ctrl_wr = bus_we && (bus_addr == REG_CTRL);
    assign stat_wr = bus_we && (bus_addr == REG_STAT);

    timer8_prescaler #(.PSC_W(PSC_W), .N_TAPS(N_TAPS)) u_psc (
        .clk    (clk),
        .rst_n  (rst_n),
        .reinit (reinit),
        .tap    (tap)
    );

    timer8_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_clk (
        .clk      (clk),
        .rst_n    (rst_n),
        .reinit   (reinit),
        .async_in (ext_clk_in),
        .rise     (ext_clk_rise)
    );

    timer8_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_clr (
        .clk      (clk),
        .rst_n    (rst_n),
        .reinit   (reinit),
        .async_in (ext_clr_in),
        .rise     (ext_clr_rise)
    );

    timer8_compare #(.W(CNT_W)) u_cmp_a (
        .clk    (clk),
        .rst_n  (rst_n),
        .reinit (reinit),
        .count  (cnt_q),
        .cmp    (cmpa_q),
        .cmp_wr (cmpa_wr),
        .hit    (hit_a)
    );

    timer8_compare #(.W(CNT_W)) u_cmp_b (
        .clk    (clk),
        .rst_n  (rst_n),
        .reinit (reinit),
        .count  (cnt_q),
        .cmp    (cmpb_q),
        .cmp_wr (cmpb_wr),
        .hit    (hit_b)
    );

    timer8_wave u_wave (
        .clk    (clk),
        .rst_n  (rst_n),
        .reinit (reinit),
        .hit_a  (hit_a),
        .hit_b  (hit_b),
        .act_a  (act_a_q),
        .act_b  (act_b_q),
        .wave   (wave_out)
    );

    // Count-clock select: hold, one prescaler tap, or the external edge
    always_comb begin
        tick = 1'b0;
        if (ctrl_q.clk_sel == CS_EXT) tick = ext_clk_rise;
        for (int i = 0; i < N_TAPS; i++) begin
            if (ctrl_q.clk_sel == 3'(i + 1)) tick = tap[i];
        end
    end

    // Clear-source select
    always_comb begin
        case (ctrl_q.clr)
            CLR_ON_A:   do_clear = hit_a;
            CLR_ON_B:   do_clear = hit_b;
            CLR_ON_EXT: do_clear = ext_clr_rise;
            default:    do_clear = 1'b0;
        endcase
    end

    assign ovf_set = tick && !cnt_wr && !do_clear && (cnt_q == CNT_MAX);

    // Counter: a bus write first, then a clear, then an increment
    always_ff @(posedge clk) begin
        if (!rst_n || reinit) cnt_q <= '0;
        else if (cnt_wr)      cnt_q <= bus_wdata;
        else if (do_clear)    cnt_q <= '0;
        else if (tick)        cnt_q <= cnt_q + 1'b1;
    end

    // Compare, control and pin-action registers
    always_ff @(posedge clk) begin
        if (!rst_n || reinit) begin
            cmpa_q  <= CNT_MAX;
            cmpb_q  <= CNT_MAX;
            ctrl_q  <= '0;
            act_a_q <= PIN_KEEP;
            act_b_q <= PIN_KEEP;
        end else begin
            if (cmpa_wr) cmpa_q <= bus_wdata;
            if (cmpb_wr) cmpb_q <= bus_wdata;
            if (ctrl_wr) ctrl_q <= ctrl_t'(bus_wdata);
            if (stat_wr) begin
                act_a_q <= pin_act_e'(bus_wdata[5:4]);
                act_b_q <= pin_act_e'(bus_wdata[7:6]);
            end
        end
    end

    // Flags: a hardware set wins over a write of 0
    always_ff @(posedge clk) begin
        if (!rst_n || reinit) begin
            flag_a   <= 1'b0;
            flag_b   <= 1'b0;
            flag_ovf <= 1'b0;
        end else begin
            flag_a   <= hit_a   | (flag_a   & ~(stat_wr & ~bus_wdata[0]));
            flag_b   <= hit_b   | (flag_b   & ~(stat_wr & ~bus_wdata[1]));
            flag_ovf <= ovf_set | (flag_ovf & ~(stat_wr & ~bus_wdata[2]));
        end
    end

    // Interrupt requests are the flags qualified by their enables
    assign irq_cma = flag_a   & ctrl_q.ie_a;
    assign irq_cmb = flag_b   & ctrl_q.ie_b;
    assign irq_ovf = flag_ovf & ctrl_q.ie_ovf;

    // Register read mux
    always_comb begin
        case (bus_addr)
            REG_COUNT: bus_rdata = cnt_q;
            REG_CMPA:  bus_rdata = cmpa_q;
            REG_CMPB:  bus_rdata = cmpb_q;
            REG_CTRL:  bus_rdata = ctrl_q;
            REG_STAT:  bus_rdata = {act_b_q, act_a_q, 1'b0, flag_ovf, flag_b, flag_a};
            default:   bus_rdata = '0;
        endcase
    end

    p_write_wins_r3: assert property (@(posedge clk) disable iff (!rst_n || reinit)
        (bus_we && bus_addr == REG_COUNT) |=> cnt_q == $past(bus_wdata));
    p_hold_code_r2: assert property (@(posedge clk) disable iff (!rst_n || reinit)
        (ctrl_q.clk_sel == CS_HOLD && ctrl_q.clr == CLR_NONE && !cnt_wr) |=> $stable(cnt_q));
    p_clear_on_a_r4: assert property (@(posedge clk) disable iff (!rst_n || reinit)
        (ctrl_q.clr == CLR_ON_A && hit_a && !cnt_wr) |=> cnt_q == '0);
    p_wrap_sets_flag_r5: assert property (@(posedge clk) disable iff (!rst_n || reinit)
        (cnt_q == CNT_MAX && tick && !cnt_wr && !do_clear) |=> (flag_ovf && cnt_q == '0));
    p_write_blocks_match_r6: assert property (@(posedge clk) disable iff (!rst_n || reinit)
        (cmpa_wr && !flag_a) |=> !flag_a);
    p_irq_follows_hit_r7: assert property (@(posedge clk) disable iff (!rst_n || reinit)
        (hit_a && ctrl_q.ie_a && !ctrl_wr) |=> irq_cma);
    p_flag_holds_r8: assert property (@(posedge clk) disable iff (!rst_n || reinit)
        (flag_a && !(stat_wr && !bus_wdata[0])) |=> flag_a);
    p_reinit_values_r10: assert property (@(posedge clk) disable iff (!rst_n)
        reinit |=> (cnt_q == '0 && cmpa_q == CNT_MAX && cmpb_q == CNT_MAX && !wave_out));

endmodule

// File: tb/dual_cmp_timer8_test.sv
`timescale 1ns/1ps
module dual_cmp_timer8_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reinit = 1'b0;
    logic       ext_clk_in = 1'b0;
    logic       ext_clr_in = 1'b0;
    logic       bus_we = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq_cma, irq_cmb, irq_ovf, wave_out;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dual_cmp_timer8 uut (
        .clk(clk), .rst_n(rst_n), .reinit(reinit),
        .ext_clk_in(ext_clk_in), .ext_clr_in(ext_clr_in),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_cma(irq_cma), .irq_cmb(irq_cmb),
        .irq_ovf(irq_ovf), .wave_out(wave_out)
    );

    localparam logic [2:0] A_CNT = 3'd0, A_CMPA = 3'd1, A_CMPB = 3'd2,
                           A_CTRL = 3'd3, A_STAT = 3'd4;

    function automatic logic [7:0] mk_ctrl(input int cs, input int clr,
                                           input bit iea, input bit ieb, input bit ieo);
        return {ieo, ieb, iea, 2'(clr), 3'(cs)};
    endfunction

    function automatic logic [7:0] mk_stat(input int osa, input int osb);
        return {2'(osb), 2'(osa), 4'b0000};
    endfunction

    function automatic int div_of(input int code);
        return 1 << (2 * code - 1);
    endfunction

    function automatic logic [7:0] exp_count(input logic [7:0] s, input int ticks);
        return 8'((int'(s) + ticks) % 256);
    endfunction

    function automatic logic [7:0] exp_wrap(input logic [7:0] s, input int ticks);
        return (int'(s) + ticks > 255) ? 8'h01 : 8'h00;
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic trigger_match;
        wr(A_CNT, 8'h00);
        wr(A_CNT, 8'h40);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int mx;
        void'($urandom(32'h5EED_0011));
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);

        // R1: reset state and read map
        rd(A_CNT, v);  chk("R1 counter", v, 8'h00);
        rd(A_CMPA, v); chk("R1 compare A", v, 8'hFF);
        rd(A_CMPB, v); chk("R1 compare B", v, 8'hFF);
        rd(A_CTRL, v); chk("R1 control", v, 8'h00);
        rd(A_STAT, v); chk("R1 status", v, 8'h00);
        rd(3'd6, v);   chk("R1 unused address", v, 8'h00);
        chk("R1 outputs", {4'h0, wave_out, irq_cma, irq_cmb, irq_ovf}, 8'h00);

        // R2: code 0 holds the counter
        wr(A_CNT, 8'h20);
        wait_cyc(50);
        rd(A_CNT, v); chk("R2 hold code", v, 8'h20);

        // R2: each prescaler ratio over an exact window
        for (int code = 1; code <= 6; code++) begin
            int win;
            win = (code == 6) ? 2 * div_of(code) : 4 * div_of(code);
            wr(A_CTRL, mk_ctrl(code, 0, 0, 0, 0));
            wr(A_CNT, 8'h00);
            wait_cyc(win);
            rd(A_CNT, v); chk($sformatf("R2 divide code %0d", code), v, 8'(win / div_of(code)));
        end

        // R2: external clock edges
        wr(A_CTRL, mk_ctrl(7, 0, 0, 0, 0));
        wr(A_CNT, 8'h00);
        for (int p = 0; p < 5; p++) begin
            ext_clk_in = 1'b1; wait_cyc(3);
            ext_clk_in = 1'b0; wait_cyc(3);
        end
        wait_cyc(4);
        rd(A_CNT, v); chk("R2 external edges", v, 8'h05);

        // R3: back-to-back counter writes under divide-by-2
        wr(A_CTRL, mk_ctrl(1, 0, 0, 0, 0));
        @(negedge clk);
        bus_we = 1'b1; bus_addr = A_CNT; bus_wdata = 8'h80;
        @(negedge clk);
        #1; chk("R3 first write", bus_rdata, 8'h80);
        bus_wdata = 8'h90;
        @(negedge clk);
        bus_we = 1'b0;
        rd(A_CNT, v); chk("R3 second write", v, 8'h90);

        // R5: wrap sets overflow flag, R7 overflow request
        wr(A_CTRL, mk_ctrl(1, 0, 0, 0, 1));
        wr(A_STAT, 8'h00);
        wr(A_CNT, 8'hFE);
        wait_cyc(8);
        rd(A_CNT, v);  chk("R5 count after wrap", v, 8'h02);
        rd(A_STAT, v); chk("R5 overflow flag", {7'd0, v[2]}, 8'h01);
        chk("R7 overflow request", {7'd0, irq_ovf}, 8'h01);

        // R8: write 1 keeps, write 0 clears
        wr(A_CTRL, mk_ctrl(0, 0, 0, 0, 1));
        wr(A_STAT, 8'h04);
        rd(A_STAT, v); chk("R8 selective clear", {5'd0, v[2:0]}, 8'h04);
        wr(A_STAT, 8'h00);
        rd(A_STAT, v); chk("R8 clear overflow", {5'd0, v[2:0]}, 8'h00);
        chk("R7 request drops", {7'd0, irq_ovf}, 8'h00);

        // R6: match A sets its flag only, R7 request A
        wr(A_CTRL, mk_ctrl(0, 0, 1, 1, 0));
        wr(A_CMPA, 8'h40);
        wr(A_CNT, 8'h00);
        wr(A_STAT, 8'h00);
        wr(A_CNT, 8'h40);
        @(negedge clk);
        rd(A_STAT, v); chk("R6 match A flags", {5'd0, v[2:0]}, 8'h01);
        chk("R7 request A", {6'd0, irq_cma, irq_cmb}, 8'h02);

        // R6: writing compare A in the hit cycle blocks the hit
        wr(A_CNT, 8'h00);
        wr(A_STAT, 8'h00);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = A_CNT; bus_wdata = 8'h40;
        @(negedge clk);
        bus_addr = A_CMPA; bus_wdata = 8'h41;
        @(negedge clk);
        bus_we = 1'b0;
        @(negedge clk);
        rd(A_STAT, v); chk("R6 blocked by write", {7'd0, v[0]}, 8'h00);

        // R8: hardware set beats a clearing write in the same cycle
        wr(A_CMPA, 8'h40);
        wr(A_CNT, 8'h00);
        wr(A_STAT, 8'h00);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = A_CNT; bus_wdata = 8'h40;
        @(negedge clk);
        bus_addr = A_STAT; bus_wdata = 8'h00;
        @(negedge clk);
        bus_we = 1'b0;
        rd(A_STAT, v); chk("R8 set wins", {7'd0, v[0]}, 8'h01);
        wr(A_STAT, 8'h00);
        wr(A_STAT, 8'h07);
        rd(A_STAT, v); chk("R8 writing ones", {5'd0, v[2:0]}, 8'h00);

        // R4: clear on A, then on B, then no clear
        wr(A_CMPA, 8'h05);
        wr(A_CTRL, mk_ctrl(1, 1, 0, 0, 0));
        wr(A_CNT, 8'h00);
        mx = 0;
        for (int c = 0; c < 100; c++) begin
            @(negedge clk); rd(A_CNT, v); if (int'(v) > mx) mx = int'(v);
        end
        chk("R4 clear on A", 8'(mx), 8'h05);
        wr(A_CMPB, 8'h03);
        wr(A_CTRL, mk_ctrl(1, 2, 0, 0, 0));
        wr(A_CNT, 8'h00);
        mx = 0;
        for (int c = 0; c < 100; c++) begin
            @(negedge clk); rd(A_CNT, v); if (int'(v) > mx) mx = int'(v);
        end
        chk("R4 clear on B", 8'(mx), 8'h03);
        wr(A_CTRL, mk_ctrl(1, 0, 0, 0, 0));
        wr(A_CNT, 8'h00);
        wait_cyc(100);
        rd(A_CNT, v); chk("R4 no clear", v, 8'd50);

        // R4: external clear edge, honoured only under code 11
        wr(A_CTRL, mk_ctrl(0, 3, 0, 0, 0));
        wr(A_CNT, 8'h33);
        ext_clr_in = 1'b1; wait_cyc(3);
        ext_clr_in = 1'b0; wait_cyc(4);
        rd(A_CNT, v); chk("R4 external clear", v, 8'h00);
        wr(A_CTRL, mk_ctrl(0, 0, 0, 0, 0));
        wr(A_CNT, 8'h33);
        ext_clr_in = 1'b1; wait_cyc(3);
        ext_clr_in = 1'b0; wait_cyc(4);
        rd(A_CNT, v); chk("R4 external clear ignored", v, 8'h33);

        // R9: pin actions, B wins on a shared hit
        wr(A_CMPA, 8'h40);
        wr(A_CMPB, 8'h40);
        wr(A_STAT, mk_stat(1, 2));
        trigger_match();
        chk("R9 B high wins", {7'd0, wave_out}, 8'h01);
        rd(A_STAT, v); chk("R7 flag without enable", {6'd0, v[1:0]}, 8'h03);
        chk("R7 no request when disabled", {6'd0, irq_cma, irq_cmb}, 8'h00);
        wr(A_STAT, mk_stat(2, 1));
        trigger_match();
        chk("R9 B low wins", {7'd0, wave_out}, 8'h00);
        wr(A_STAT, mk_stat(2, 0));
        trigger_match();
        chk("R9 B keep wins", {7'd0, wave_out}, 8'h00);
        wr(A_CMPB, 8'h99);
        wr(A_STAT, mk_stat(3, 0));
        trigger_match();
        chk("R9 toggle high", {7'd0, wave_out}, 8'h01);
        trigger_match();
        chk("R9 toggle low", {7'd0, wave_out}, 8'h00);

        // R10: reinitialization
        wr(A_CMPA, 8'h12);
        wr(A_CNT, 8'h34);
        wr(A_CTRL, mk_ctrl(2, 1, 1, 0, 1));
        wr(A_STAT, mk_stat(3, 0));
        trigger_match();
        @(negedge clk);
        reinit = 1'b1;
        @(negedge clk);
        reinit = 1'b0;
        rd(A_CNT, v);  chk("R10 counter", v, 8'h00);
        rd(A_CMPA, v); chk("R10 compare A", v, 8'hFF);
        rd(A_CMPB, v); chk("R10 compare B", v, 8'hFF);
        rd(A_CTRL, v); chk("R10 control", v, 8'h00);
        rd(A_STAT, v); chk("R10 status", v, 8'h00);
        chk("R10 pin", {7'd0, wave_out}, 8'h00);

        // R2 and R5 under random start values and windows
        for (int it = 0; it < 24; it++) begin
            int code, mult;
            logic [7:0] s;
            code = 1 + int'($urandom % 3);
            mult = 1 + int'($urandom % 16);
            s    = 8'($urandom % 256);
            wr(A_CTRL, mk_ctrl(0, 0, 0, 0, 0));
            wr(A_CNT, s);
            wr(A_STAT, 8'h00);
            wr(A_CTRL, mk_ctrl(code, 0, 0, 0, 0));
            wait_cyc(mult * div_of(code));
            rd(A_CNT, v);  chk("R2 random window", v, exp_count(s, mult));
            rd(A_STAT, v); chk("R5 random wrap", {7'd0, v[2]}, exp_wrap(s, mult));
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule